// File: doc/BRIEF.md
# Receiver Eye Width Scan Controller

This controller measures the horizontal opening of a receiver's data eye. On a start pulse it walks the sampling-phase code that drives a phase interpolator from a low bound to a high bound in fixed increments. At each code it waits for the sampler to settle. It then counts the error pulses that a pattern checker raises while a fixed number of checked bits go by. A code is judged good when that error count is no larger than a set threshold.

For a healthy link the errors are high at the edges of the sweep, low in the middle, and high again. The controller therefore keeps the longest unbroken stretch of good codes and reports three things: its length, its first code and its last code. A stretch of length zero is flagged as a closed eye. A vertical-height value is captured at start and held steady on its own output for the sampler during the scan.

The interpolator, sampler, deserializer and pattern source sit outside the block. The bench models them.

Top module: `eye_scan_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `eyeClosed`, `eyeWidth`, `eyeFirst`, `eyeLast`, `vertCode` and `phaseCode` are all 0.
- R2: A `start` pulse seen while idle or done takes effect at that clock edge. From the next cycle `busy`=1 and `done`=0, `phaseCode` equals `phaseMin`, and `vertCode` equals `vertIn` as sampled with `start`.
- R3: Each phase code is held for SETTLE_CYC cycles. It is then held for as many cycles as it takes to see WINDOW_LEN `bitValid` strobes, plus one evaluation cycle. With `bitValid` high on every cycle the hold time is SETTLE_CYC+WINDOW_LEN+1 cycles.
- R4: `errPulse` is counted only during the strobe window, with the count saturating. A code is good exactly when its count is at or below ERR_THRESH.
- R5: After each code the phase advances by `phaseStep`, and a step of 0 is used as 1. The scan ends after the last code that is at or below `phaseMax`. The sum is formed one bit wider, so it never wraps back into range. When `phaseMin` > `phaseMax`, exactly one code is measured.
- R6: At done, `eyeWidth` is the number of codes in the longest run of consecutive good codes. When two runs are equally long, the earliest one is reported.
- R7: At done, `eyeFirst` and `eyeLast` are the first and last phase codes of that run. Both are 0 when no code was good.
- R8: At done, `eyeClosed` is 1 exactly when `eyeWidth` is 0.
- R9: `done` and all results stay steady until the next `start`. `busy` and `done` are never high together.
- R10: A `start` pulse while `busy` is high has no effect on the scan in progress or on its results.
- R11: `vertCode` does not change while `busy` is high, whatever `vertIn` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (one-cycle pulse) |
| phaseMin | input | PHASE_W | First phase code of the sweep |
| phaseMax | input | PHASE_W | Highest phase code allowed in the sweep |
| phaseStep | input | PHASE_W | Increment between codes (0 is used as 1) |
| vertIn | input | V_W | Vertical-height setting captured at start |
| errPulse | input | 1 | One pulse per error from the pattern checker |
| bitValid | input | 1 | One strobe per checked bit |
| phaseCode | output | PHASE_W | Phase code to the interpolator |
| vertCode | output | V_W | Held vertical-height setting to the sampler |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, results valid |
| eyeWidth | output | PHASE_W+1 | Length of the longest good run |
| eyeFirst | output | PHASE_W | First code of that run |
| eyeLast | output | PHASE_W | Last code of that run |
| eyeClosed | output | 1 | No good code found |

## Verification
The bench builds the block with a 5-bit phase code, a 16-strobe window, 4 settle cycles and an error threshold of 2. With these values every sweep finishes in a few hundred cycles.

Because the window is short, a checker that errs every 8th cycle lands exactly on the threshold (2 errors), and one that errs every 4th cycle lands just above it (4 errors). That lets the bench test the boundary directly.

The 5-bit code is small enough that a base of 30 plus a step of 5 overflows the code width. That case checks that the scan does not wrap back into range. Other sweeps cover stray good codes outside the main opening, equally long runs, strides larger than one, a step of zero and gaps in the bit strobe.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadScan;   // capture settings, reset results
    logic settleRun;  // settle phase active
    logic measRun;    // error window active
    logic evalStep;   // judge step, advance phase
  } scanCtrl_t;

  // Status from datapath to control
  typedef struct packed {
    logic settleDone;
    logic windowDone;
    logic lastStep;
  } scanStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_MEASURE,
    ST_EVAL,
    ST_DONE
  } scanState_t;

endpackage

// File: rtl/eye_scan_fsm.sv
module eye_scan_fsm
  import eye_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  scanStat_t stat,
  output scanCtrl_t ctrl,
  output logic      busy,
  output logic      done
);

  scanState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctrl.loadScan = 1'b1;
          stateNext     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        ctrl.settleRun = 1'b1;
        if (stat.settleDone) stateNext = ST_MEASURE;
      end
      ST_MEASURE: begin
        ctrl.measRun = 1'b1;
        if (stat.windowDone) stateNext = ST_EVAL;
      end
      ST_EVAL: begin
        ctrl.evalStep = 1'b1;
        stateNext     = stat.lastStep ? ST_DONE : ST_SETTLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_SETTLE) || (state == ST_MEASURE) || (state == ST_EVAL);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/eye_scan_datapath.sv
module eye_scan_datapath
  import eye_scan_pkg::*;
#(
  parameter int PHASE_W    = 7,
  parameter int V_W        = 6,
  parameter int WINDOW_LEN = 65536,
  parameter int SETTLE_CYC = 32,
  parameter int ERR_THRESH = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  scanCtrl_t          ctrl,
  output scanStat_t          stat,
  input  logic [PHASE_W-1:0] phaseMin,
  input  logic [PHASE_W-1:0] phaseMax,
  input  logic [PHASE_W-1:0] phaseStep,
  input  logic [V_W-1:0]     vertIn,
  input  logic               errPulse,
  input  logic               bitValid,
  output logic [PHASE_W-1:0] phaseCode,
  output logic [V_W-1:0]     vertCode,
  output logic [PHASE_W:0]   eyeWidth,
  output logic [PHASE_W-1:0] eyeFirst,
  output logic [PHASE_W-1:0] eyeLast,
  output logic               eyeClosed
);

  localparam int WIDTH_W = PHASE_W + 1;
  localparam int BIT_W   = $clog2(WINDOW_LEN + 1);
  localparam int ERR_W   = BIT_W;
  localparam int SET_W   = $clog2(SETTLE_CYC + 1);
  localparam logic [BIT_W-1:0] BIT_LAST    = BIT_W'(WINDOW_LEN - 1);
  localparam logic [SET_W-1:0] SETTLE_LAST = SET_W'(SETTLE_CYC - 1);
  localparam logic [ERR_W-1:0] THRESH_V    =
    (ERR_THRESH >= WINDOW_LEN) ? {ERR_W{1'b1}} : ERR_W'(ERR_THRESH);

  logic [PHASE_W-1:0] stepReg, maxReg;
  logic [SET_W-1:0]   settleCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [ERR_W-1:0]   errCnt;
  logic [WIDTH_W-1:0] curLen, bestLen;
  logic [PHASE_W-1:0] curFirst, bestFirst, bestLast;

  // Next phase, one bit wider so it cannot wrap
  logic [PHASE_W:0] phaseSum;
  assign phaseSum = {1'b0, phaseCode} + {1'b0, stepReg};

  assign stat.settleDone = (settleCnt == SETTLE_LAST);
  assign stat.windowDone = bitValid && (bitCnt == BIT_LAST);
  assign stat.lastStep   = (phaseSum > {1'b0, maxReg});

  // Run tracking
  logic               stepGood;
  logic [WIDTH_W-1:0] runLenNext;
  logic [PHASE_W-1:0] runFirstNext;
  logic               runBetter;
  logic [WIDTH_W-1:0] bestLenNext;

  assign stepGood     = (errCnt <= THRESH_V);
  assign runLenNext   = curLen + 1'b1;
  assign runFirstNext = (curLen == '0) ? phaseCode : curFirst;
  assign runBetter    = stepGood && (runLenNext > bestLen);
  assign bestLenNext  = runBetter ? runLenNext : bestLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCode <= '0;
      vertCode  <= '0;
      stepReg   <= '0;
      maxReg    <= '0;
      settleCnt <= '0;
      bitCnt    <= '0;
      errCnt    <= '0;
      curLen    <= '0;
      curFirst  <= '0;
      bestLen   <= '0;
      bestFirst <= '0;
      bestLast  <= '0;
      eyeClosed <= 1'b0;
    end else begin
      if (ctrl.loadScan) begin
        phaseCode <= phaseMin;
        vertCode  <= vertIn;
        stepReg   <= (phaseStep == '0) ? PHASE_W'(1) : phaseStep;
        maxReg    <= phaseMax;
        settleCnt <= '0;
        curLen    <= '0;
        curFirst  <= '0;
        bestLen   <= '0;
        bestFirst <= '0;
        bestLast  <= '0;
        eyeClosed <= 1'b0;
      end
      if (ctrl.settleRun) begin
        settleCnt <= settleCnt + 1'b1;
        bitCnt    <= '0;
        errCnt    <= '0;
      end
      if (ctrl.measRun) begin
        if (bitValid) bitCnt <= bitCnt + 1'b1;
        if (errPulse && (errCnt != {ERR_W{1'b1}})) errCnt <= errCnt + 1'b1;
      end
      if (ctrl.evalStep) begin
        settleCnt <= '0;
        if (stepGood) begin
          curLen   <= runLenNext;
          curFirst <= runFirstNext;
        end else begin
          curLen <= '0;
        end
        if (runBetter) begin
          bestLen   <= runLenNext;
          bestFirst <= runFirstNext;
          bestLast  <= phaseCode;
        end
        if (stat.lastStep) eyeClosed <= (bestLenNext == '0);
        else               phaseCode <= phaseSum[PHASE_W-1:0];
      end
    end
  end

  assign eyeWidth = bestLen;
  assign eyeFirst = bestFirst;
  assign eyeLast  = bestLast;

endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl
  import eye_scan_pkg::*;
#(
  parameter int PHASE_W    = 7,
  parameter int V_W        = 6,
  parameter int WINDOW_LEN = 65536,
  parameter int SETTLE_CYC = 32,
  parameter int ERR_THRESH = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PHASE_W-1:0] phaseMin,
  input  logic [PHASE_W-1:0] phaseMax,
  input  logic [PHASE_W-1:0] phaseStep,
  input  logic [V_W-1:0]     vertIn,
  input  logic               errPulse,
  input  logic               bitValid,
  output logic [PHASE_W-1:0] phaseCode,
  output logic [V_W-1:0]     vertCode,
  output logic               busy,
  output logic               done,
  output logic [PHASE_W:0]   eyeWidth,
  output logic [PHASE_W-1:0] eyeFirst,
  output logic [PHASE_W-1:0] eyeLast,
  output logic               eyeClosed
);

  scanCtrl_t ctrl;
  scanStat_t stat;

  eye_scan_fsm u_fsm (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  eye_scan_datapath #(
    .PHASE_W    (PHASE_W),
    .V_W        (V_W),
    .WINDOW_LEN (WINDOW_LEN),
    .SETTLE_CYC (SETTLE_CYC),
    .ERR_THRESH (ERR_THRESH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .stat      (stat),
    .phaseMin  (phaseMin),
    .phaseMax  (phaseMax),
    .phaseStep (phaseStep),
    .vertIn    (vertIn),
    .errPulse  (errPulse),
    .bitValid  (bitValid),
    .phaseCode (phaseCode),
    .vertCode  (vertCode),
    .eyeWidth  (eyeWidth),
    .eyeFirst  (eyeFirst),
    .eyeLast   (eyeLast),
    .eyeClosed (eyeClosed)
  );

endmodule

// File: rtl/eye_scan_checker.sv
module eye_scan_checker #(
  parameter int PHASE_W = 7,
  parameter int V_W     = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [PHASE_W-1:0] phaseCode,
  input logic [V_W-1:0]     vertCode,
  input logic [PHASE_W:0]   eyeWidth,
  input logic [PHASE_W-1:0] eyeFirst,
  input logic [PHASE_W-1:0] eyeLast,
  input logic               eyeClosed
);

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(eyeWidth) && $stable(eyeFirst) && $stable(eyeLast));

  assert_closed_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (eyeClosed == (eyeWidth == '0)));

  assert_run_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && !eyeClosed |-> (eyeLast >= eyeFirst));

  assert_vert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> busy -> $stable(vertCode));

  assert_phase_no_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> busy -> (phaseCode >= $past(phaseCode)));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> (busy || done) && (phaseCode >= $past(phaseCode)));

endmodule

bind eye_scan_ctrl eye_scan_checker #(.PHASE_W(PHASE_W), .V_W(V_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .phaseCode (phaseCode),
  .vertCode  (vertCode),
  .eyeWidth  (eyeWidth),
  .eyeFirst  (eyeFirst),
  .eyeLast   (eyeLast),
  .eyeClosed (eyeClosed)
);

// File: tb/tb_eye_scan_ctrl.sv
module tb_eye_scan_ctrl;

  localparam int PHASE_W = 5;
  localparam int V_W     = 4;
  localparam int WIN     = 16;
  localparam int SETTLE  = 4;
  localparam int THRESH  = 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [PHASE_W-1:0] phaseMin = '0, phaseMax = '0, phaseStep = '0;
  logic [V_W-1:0]     vertIn = '0;
  logic               errPulse = 1'b0, bitValid = 1'b0;
  logic [PHASE_W-1:0] phaseCode, eyeFirst, eyeLast;
  logic [V_W-1:0]     vertCode;
  logic               busy, done, eyeClosed;
  logic [PHASE_W:0]   eyeWidth;

  always #2 clk = ~clk;  // 250 MHz

  eye_scan_ctrl #(
    .PHASE_W(PHASE_W), .V_W(V_W), .WINDOW_LEN(WIN),
    .SETTLE_CYC(SETTLE), .ERR_THRESH(THRESH)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .phaseMin(phaseMin), .phaseMax(phaseMax), .phaseStep(phaseStep),
    .vertIn(vertIn), .errPulse(errPulse), .bitValid(bitValid),
    .phaseCode(phaseCode), .vertCode(vertCode), .busy(busy), .done(done),
    .eyeWidth(eyeWidth), .eyeFirst(eyeFirst), .eyeLast(eyeLast),
    .eyeClosed(eyeClosed)
  );

  // Stimulus vectors: range, per-code error level masks, expected result
  typedef struct packed {
    logic [4:0]  lo, hi, st;
    logic [31:0] bad;    // error every cycle
    logic [31:0] mid;    // error every 4th cycle: 4 per window, over threshold
    logic [31:0] light;  // error every 8th cycle: 2 per window, at threshold
    logic        gap;    // bit strobe on alternate cycles
    logic [5:0]  w;
    logic [4:0]  f, l;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{5'd0,  5'd15, 5'd1, 32'hFFFFFC1F, 32'h0,  32'h0,  1'b0, 6'd5, 5'd5,  5'd9},
    '{5'd0,  5'd20, 5'd1, 32'hFFFE70FB, 32'h0,  32'h0,  1'b0, 6'd4, 5'd8,  5'd11},
    '{5'd3,  5'd12, 5'd1, 32'hFFFFFFFF, 32'h0,  32'h0,  1'b0, 6'd0, 5'd0,  5'd0},
    '{5'd1,  5'd25, 5'd3, 32'hFFF7DB7F, 32'h0,  32'h0,  1'b0, 6'd3, 5'd7,  5'd13},
    '{5'd0,  5'd7,  5'd1, 32'hFFFFFF81, 32'h42, 32'h3C, 1'b0, 6'd4, 5'd2,  5'd5},
    '{5'd0,  5'd9,  5'd1, 32'hFFFFFF39, 32'h0,  32'h0,  1'b0, 6'd2, 5'd1,  5'd2},
    '{5'd10, 5'd14, 5'd1, 32'h0,        32'h0,  32'h0,  1'b0, 6'd5, 5'd10, 5'd14},
    '{5'd30, 5'd31, 5'd5, 32'h0,        32'h0,  32'h0,  1'b0, 6'd1, 5'd30, 5'd30},
    '{5'd4,  5'd6,  5'd0, 32'h00000020, 32'h0,  32'h0,  1'b1, 6'd1, 5'd4,  5'd4}
  };

  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  vec_t cur;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pattern checker model, driven on the falling edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    bitValid <= cur.gap ? cyc[0] : 1'b1;
    if (cur.bad[phaseCode])        errPulse <= 1'b1;
    else if (cur.mid[phaseCode])   errPulse <= (cyc % 4 == 0);
    else if (cur.light[phaseCode]) errPulse <= (cyc % 8 == 0);
    else                           errPulse <= 1'b0;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic startScan(input vec_t v, input logic [V_W-1:0] vv);
    @(negedge clk);
    cur       = v;
    phaseMin  = v.lo;
    phaseMax  = v.hi;
    phaseStep = v.st;
    vertIn    = vv;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R9 scan completes", int'(done), 1);
  endtask

  task automatic checkResult(input vec_t v, input string tag);
    chk(eyeWidth == v.w, {tag, " R6 width"}, int'(eyeWidth), int'(v.w));
    chk(eyeFirst == v.f, {tag, " R7 first"}, int'(eyeFirst), int'(v.f));
    chk(eyeLast  == v.l, {tag, " R7 last"},  int'(eyeLast),  int'(v.l));
    chk(eyeClosed == (v.w == 0), {tag, " R8 closed"}, int'(eyeClosed), int'(v.w == 0));
  endtask

  initial begin
    cur = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
    chk(eyeWidth == 0 && !eyeClosed, "R1 width/closed", int'(eyeWidth), 0);
    chk(phaseCode == 0 && vertCode == 0, "R1 phase/vert", int'(phaseCode), 0);
    chk(eyeFirst == 0 && eyeLast == 0, "R1 first/last", int'(eyeFirst), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table walk (R4 R5 R6 R7 R8)
    for (int i = 0; i < NVEC; i++) begin
      startScan(VECS[i], 4'(i));
      waitDone();
      checkResult(VECS[i], $sformatf("vec%0d", i));
    end

    // R2 start response and R11 vertical hold
    startScan(VECS[6], 4'hA);
    chk(busy && !done, "R2 busy after start", int'({busy, done}), 2);
    chk(phaseCode == VECS[6].lo, "R2 phase loaded", int'(phaseCode), int'(VECS[6].lo));
    chk(vertCode == 4'hA, "R2 vert latched", int'(vertCode), 10);
    vertIn = 4'h5;
    // R3 dwell: code held SETTLE+WIN+1 cycles (start edge included)
    begin
      int held = 1;
      while (phaseCode == VECS[6].lo && held < 200) begin
        @(negedge clk);
        if (phaseCode == VECS[6].lo) held++;
      end
      chk(held == SETTLE + WIN + 1, "R3 dwell", held, SETTLE + WIN + 1);
      chk(phaseCode == VECS[6].lo + 1, "R5 advance", int'(phaseCode), int'(VECS[6].lo) + 1);
    end
    waitDone();
    chk(vertCode == 4'hA, "R11 vert held", int'(vertCode), 10);
    checkResult(VECS[6], "dwell");

    // R9 done and results hold
    repeat (40) @(negedge clk);
    chk(done && !busy, "R9 done holds", int'(done), 1);
    chk(eyeWidth == VECS[6].w, "R9 width holds", int'(eyeWidth), int'(VECS[6].w));

    // R10 start during busy is ignored
    startScan(VECS[0], 4'h3);
    repeat (30) @(negedge clk);
    phaseMin = 5'd20;
    phaseMax = 5'd31;
    vertIn   = 4'hC;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && phaseCode != 5'd20, "R10 no restart", int'(phaseCode), 1);
    waitDone();
    checkResult(VECS[0], "R10 busy start");
    chk(vertCode == 4'h3, "R10 vert kept", int'(vertCode), 3);

    // R2 done drops on new start
    startScan(VECS[7], 4'h1);
    chk(!done && busy, "R2 done cleared", int'(done), 0);
    waitDone();
    checkResult(VECS[7], "restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule